// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Controller

This block holds the control and status state for one DMA channel that walks a linked list of buffer descriptors. A processor writes a one-byte command that starts or halts list processing and chooses how the end of the list is reported. The block tracks two descriptor slots. The base slot holds the next buffer to run. The current slot holds the buffer in progress. The block asks for the next descriptor with a prefetch request, and that request competes inside the channel with the channel's own transfer request.

The data path and descriptor parsing sit outside the block and appear only as handshakes. `fetch_ack` loads a descriptor into the base slot, and `fetch_last` says that this descriptor ends the list. `buf_done` says the current buffer has expired. When the final buffer completes, the block gives either a one-cycle end-of-process strobe or a held interrupt, depending on a stored selection.

Top module: `sg_dma_ctrl`

## Requirements
- R1: After reset or a `master_clr` cycle, `sg_status` reads 8'h06, `chan_mask` is 1, the termination selection is 0 (interrupt), and `eop_pulse`, `term_irq` and `chan_req` are 0. Status bit positions are: [0] active, [1] base slot empty, [2] current slot empty, [3] terminated, [4] next-null (the end of the list has been loaded), [7] stored selection, and [6:5] always 0.
- R2: A write with code `cmd_byte[1:0]`=01 (start) sets the channel active, marks both slots empty, clears terminated and next-null, clears `chan_mask` and `term_irq`, and makes a prefetch request pending from the next cycle.
- R3: A write with code 10 (stop) clears active, sets terminated and `chan_mask`, and drops any pending prefetch in the next cycle.
- R4: Code 00 changes no state except the selection. Code 11 behaves like 00. `cmd_byte[5:2]` have no effect.
- R5: `cmd_byte[7]` is stored as the termination selection only when `cmd_byte[6]` of the same write is 1. This applies with any command code. Otherwise the selection keeps its value.
- R6: A start leaves the stored selection unchanged unless bit 6 of that same write updates it.
- R7: `chan_req` = active & !mask & (`xfer_req` | prefetch pending). `chan_fetch` is 1 only when a prefetch is pending and `xfer_req` is 0, so the transfer request wins inside the channel.
- R8: `fetch_ack` counts only while `chan_fetch` is 1. It fills the base slot, sets next-null from `fetch_last`, and clears the pending prefetch.
- R9: When the base slot is full and the current slot is empty or `buf_done` is high, the base slot moves to the current slot on the next edge, and a new prefetch becomes pending unless next-null is set.
- R10: `buf_done` with the current slot full, the base slot empty and next-null set ends the list. Active clears and terminated sets on the next edge. On that same edge, `eop_pulse` rises for exactly one cycle if the selection is 1, or `term_irq` rises if the selection is 0.
- R11: `term_irq` stays high until a start, reset or master clear.
- R12: `buf_done` with the current slot empty and `fetch_ack` while `chan_fetch` is 0 leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_clr | input | 1 | Synchronous clear with the same effect as reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte: [1:0] code, [6] selection enable, [7] selection |
| xfer_req | input | 1 | Channel transfer request from the device |
| fetch_ack | input | 1 | Descriptor fetch completed |
| fetch_last | input | 1 | Fetched descriptor is the end of the list |
| buf_done | input | 1 | Current buffer has expired |
| chan_req | output | 1 | Channel service request to the system arbiter |
| chan_fetch | output | 1 | The request being presented is a descriptor prefetch |
| chan_mask | output | 1 | Channel mask |
| sg_status | output | 8 | Status byte |
| eop_pulse | output | 1 | One-cycle end-of-process strobe |
| term_irq | output | 1 | Held termination interrupt |

## Verification
A wrong slot flag shows up in `sg_status` on the edge after the event that caused it. It also shows as a prefetch that is missing or extra on `chan_fetch` in the same cycle. A wrong stored selection stays hidden until the list ends, because it only shows when the wrong termination output fires. For that reason, each selection path is run through a full list to completion. A bad next-null flag shows one edge later than a bad slot flag: either a refetch appears after the last descriptor, or a buffer completes without terminating the list.

// File: rtl/sg_dma_pkg.sv
// Shared definitions for the scatter-gather channel controller.
// Assumes an 8-bit command byte and an 8-bit status byte.
package sg_dma_pkg;
    localparam int CMD_W  = 8;
    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        SG_NOP   = 2'b00,
        SG_START = 2'b01,
        SG_STOP  = 2'b10,
        SG_RSVD  = 2'b11
    } sg_code_e;

    // Status bit positions
    localparam int ST_ACTIVE = 0;
    localparam int ST_BEMPTY = 1;
    localparam int ST_CEMPTY = 2;
    localparam int ST_TERM   = 3;
    localparam int ST_NULL   = 4;
    localparam int ST_SEL    = 7;
endpackage

// File: rtl/sg_cmd_decode.sv
// Command decoder: turns a command write into start and stop pulses and
// holds the termination selection, which changes only under bit 6.
// Assumes cmd_wr is a single-cycle strobe.
module sg_cmd_decode
    import sg_dma_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master_clr,
    input  logic         cmd_wr,
    input  logic [W-1:0] cmd_byte,
    output logic         start_p,
    output logic         stop_p,
    output logic         sel_eop
);
    sg_code_e code;

    // Decode the command code of the current write
    always_comb begin
        code    = sg_code_e'(cmd_byte[1:0]);
        start_p = cmd_wr && (code == SG_START);
        stop_p  = cmd_wr && (code == SG_STOP);
    end

    // Sticky termination selection, written only when bit 6 is set
    always_ff @(posedge clk) begin
        if (!rst_n || master_clr)
            sel_eop <= 1'b0;
        else if (cmd_wr && cmd_byte[6])
            sel_eop <= cmd_byte[7];
    end

    a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_byte[6] && !master_clr) |=> $stable(sel_eop));
    a_r5_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_byte[6] && !master_clr) |=> (sel_eop == $past(cmd_byte[7])));
endmodule

// File: rtl/sg_req_arb.sv
// In-channel arbitration: the transfer request outranks the prefetch.
// Assumes the channel is enabled only while it is active and unmasked.
module sg_req_arb (
    input  logic en,
    input  logic xfer_req,
    input  logic pf_pend,
    output logic chan_req,
    output logic chan_fetch
);
    // Combine the requests and give priority to the transfer
    always_comb begin
        chan_req   = en && (xfer_req || pf_pend);
        chan_fetch = en && pf_pend && !xfer_req;
    end

    always_comb begin
        a_r7_xfer_wins: assert (!(xfer_req && chan_fetch));
    end
endmodule

// File: rtl/sg_slot_tracker.sv
// Slot tracker: keeps the base and current slots, the prefetch request,
// the list state, and the termination outputs.
// Assumes fetch_take only arrives while the base slot is empty.
module sg_slot_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic master_clr,
    input  logic start_p,
    input  logic stop_p,
    input  logic sel_eop,
    input  logic fetch_take,
    input  logic fetch_last,
    input  logic buf_done,
    output logic active,
    output logic base_full,
    output logic cur_full,
    output logic term,
    output logic nxt_null,
    output logic mask,
    output logic pf_pend,
    output logic eop_pulse,
    output logic term_irq
);
    logic promote, finish;

    // Decide whether the slots advance or the list ends this cycle
    always_comb begin
        promote = active && base_full && (!cur_full || buf_done);
        finish  = active && !promote && buf_done && cur_full && nxt_null;
    end

    // Channel list state machine
    always_ff @(posedge clk) begin
        if (!rst_n || master_clr) begin
            active    <= 1'b0;
            base_full <= 1'b0;
            cur_full  <= 1'b0;
            term      <= 1'b0;
            nxt_null  <= 1'b0;
            mask      <= 1'b1;
            pf_pend   <= 1'b0;
            eop_pulse <= 1'b0;
            term_irq  <= 1'b0;
        end else begin
            eop_pulse <= 1'b0;
            if (start_p) begin
                active    <= 1'b1;
                base_full <= 1'b0;
                cur_full  <= 1'b0;
                term      <= 1'b0;
                nxt_null  <= 1'b0;
                mask      <= 1'b0;
                pf_pend   <= 1'b1;
                term_irq  <= 1'b0;
            end else if (stop_p) begin
                active  <= 1'b0;
                term    <= 1'b1;
                mask    <= 1'b1;
                pf_pend <= 1'b0;
            end else if (active) begin
                if (fetch_take) begin
                    base_full <= 1'b1;
                    nxt_null  <= fetch_last;
                    pf_pend   <= 1'b0;
                end
                if (promote) begin
                    base_full <= 1'b0;
                    cur_full  <= 1'b1;
                    pf_pend   <= !nxt_null;
                end else if (buf_done && cur_full) begin
                    cur_full <= 1'b0;
                    if (finish) begin
                        active <= 1'b0;
                        term   <= 1'b1;
                        if (sel_eop) eop_pulse <= 1'b1;
                        else         term_irq  <= 1'b1;
                    end
                end
            end
        end
    end

    a_r2_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && !master_clr) |=> (active && !base_full && !cur_full && !term && pf_pend && !mask));
    a_r3_stop_state: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_p && !start_p && !master_clr) |=> (!active && term && mask && !pf_pend));
    a_r10_eop_single: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |=> !eop_pulse);
    a_r10_eop_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eop_pulse) |-> (sel_eop && term && !active));
    a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (term_irq && !start_p && !master_clr) |=> term_irq);
endmodule

// File: rtl/sg_dma_ctrl.sv
// Top of the scatter-gather channel controller. Connects the decoder,
// the slot tracker and the in-channel arbiter, and packs the status byte.
// Assumes a synchronous active-low reset.
module sg_dma_ctrl
    import sg_dma_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_clr,
    input  logic          cmd_wr,
    input  logic [CW-1:0] cmd_byte,
    input  logic          xfer_req,
    input  logic          fetch_ack,
    input  logic          fetch_last,
    input  logic          buf_done,
    output logic          chan_req,
    output logic          chan_fetch,
    output logic          chan_mask,
    output logic [SW-1:0] sg_status,
    output logic          eop_pulse,
    output logic          term_irq
);
    logic start_p, stop_p, sel_eop;
    logic active, base_full, cur_full, term, nxt_null, pf_pend;

    sg_cmd_decode #(.W(CW)) u_dec (
        .clk(clk), .rst_n(rst_n), .master_clr(master_clr),
        .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .start_p(start_p), .stop_p(stop_p), .sel_eop(sel_eop)
    );

    sg_slot_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .master_clr(master_clr),
        .start_p(start_p), .stop_p(stop_p), .sel_eop(sel_eop),
        .fetch_take(fetch_ack && chan_fetch), .fetch_last(fetch_last),
        .buf_done(buf_done),
        .active(active), .base_full(base_full), .cur_full(cur_full),
        .term(term), .nxt_null(nxt_null), .mask(chan_mask),
        .pf_pend(pf_pend), .eop_pulse(eop_pulse), .term_irq(term_irq)
    );

    sg_req_arb u_arb (
        .en(active && !chan_mask), .xfer_req(xfer_req), .pf_pend(pf_pend),
        .chan_req(chan_req), .chan_fetch(chan_fetch)
    );

    // Pack the status byte
    always_comb begin
        sg_status            = '0;
        sg_status[ST_ACTIVE] = active;
        sg_status[ST_BEMPTY] = !base_full;
        sg_status[ST_CEMPTY] = !cur_full;
        sg_status[ST_TERM]   = term;
        sg_status[ST_NULL]   = nxt_null;
        sg_status[ST_SEL]    = sel_eop;
    end

    a_r1_clear_state: assert property (@(posedge clk)
        (!rst_n || master_clr) |=> (sg_status == 8'h06 && chan_mask && !term_irq && !eop_pulse));
    a_r10_irq_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_irq) |-> (!sg_status[ST_SEL] && sg_status[ST_TERM]));
endmodule

// File: tb/sg_dma_ctrl_test.sv
module sg_dma_ctrl_test;
    logic clk = 0;
    logic rst_n = 0, master_clr = 0, cmd_wr = 0;
    logic [7:0] cmd_byte = 0;
    logic xfer_req = 0, fetch_ack = 0, fetch_last = 0, buf_done = 0;
    logic chan_req, chan_fetch, chan_mask, eop_pulse, term_irq;
    logic [7:0] sg_status;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sg_dma_ctrl uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] v);
        cmd_wr = 1; cmd_byte = v; step(); cmd_wr = 0; cmd_byte = 0;
    endtask

    function automatic logic [7:0] st(input bit sel, nul, trm, ce, be, act);
        return {sel, 2'b00, nul, trm, ce, be, act};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit m_act, m_be, m_ce, m_term, m_null, m_sel, m_mask, m_pf;
        step(); step(); rst_n = 1; step();
        // R1 reset state
        chk("R1 status", sg_status, 8'h06);
        chk("R1 mask", chan_mask, 1);
        chk("R1 irq/eop/req", {term_irq, eop_pulse, chan_req}, 0);

        // R2 R3 R4 R5 R6 sweep of every command byte
        m_act = 0; m_be = 1; m_ce = 1; m_term = 0; m_null = 0; m_sel = 0; m_mask = 1; m_pf = 0;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = v[7:0];
            wr(b);
            if (b[6]) m_sel = b[7];
            if (b[1:0] == 2'b01) begin
                m_act = 1; m_be = 1; m_ce = 1; m_term = 0; m_null = 0; m_mask = 0; m_pf = 1;
            end else if (b[1:0] == 2'b10) begin
                m_act = 0; m_term = 1; m_mask = 1; m_pf = 0;
            end
            chk("R2 R3 R4 R5 R6 sweep status", sg_status, st(m_sel, m_null, m_term, m_ce, m_be, m_act));
            chk("R3 sweep mask", chan_mask, m_mask);
            chk("R7 sweep req", chan_req, m_act && !m_mask && m_pf);
        end

        // R1 master clear
        master_clr = 1; step(); master_clr = 0;
        chk("R1 master clear status", sg_status, 8'h06);

        // EOP path through a two-descriptor list
        wr(8'hC0); wr(8'h01);
        chk("R6 start keeps sel", sg_status, st(1, 0, 0, 1, 1, 1));
        buf_done = 1; step(); buf_done = 0;
        chk("R12 done on empty cur", sg_status, st(1, 0, 0, 1, 1, 1));
        xfer_req = 1; #1;
        chk("R7 xfer wins", {chan_req, chan_fetch}, 2'b10);
        fetch_ack = 1; step(); fetch_ack = 0;
        chk("R12 ack without fetch grant", sg_status, st(1, 0, 0, 1, 1, 1));
        xfer_req = 0; #1;
        chk("R7 prefetch shown", {chan_req, chan_fetch}, 2'b11);
        fetch_ack = 1; fetch_last = 0; step(); fetch_ack = 0;
        chk("R8 base loaded", sg_status, st(1, 0, 0, 1, 0, 1));
        chk("R8 pending cleared", chan_fetch, 0);
        step();
        chk("R9 promote", sg_status, st(1, 0, 0, 0, 1, 1));
        chk("R9 refetch", chan_fetch, 1);
        fetch_ack = 1; fetch_last = 1; step(); fetch_ack = 0; fetch_last = 0;
        chk("R8 last loaded", sg_status, st(1, 1, 0, 0, 0, 1));
        step();
        chk("R9 hold both full", sg_status, st(1, 1, 0, 0, 0, 1));
        buf_done = 1; step(); buf_done = 0;
        chk("R9 promote on done", sg_status, st(1, 1, 0, 0, 1, 1));
        chk("R9 no fetch after null", chan_req, 0);
        buf_done = 1; step(); buf_done = 0;
        chk("R10 terminated", sg_status, st(1, 1, 1, 1, 1, 0));
        chk("R10 eop pulse", {eop_pulse, term_irq}, 2'b10);
        step();
        chk("R10 eop single cycle", eop_pulse, 0);

        // Interrupt path with a single descriptor
        wr(8'h40); wr(8'h01);
        fetch_ack = 1; fetch_last = 1; step(); fetch_ack = 0; fetch_last = 0;
        step();
        chk("R9 single promote", sg_status, st(0, 1, 0, 0, 1, 1));
        buf_done = 1; step(); buf_done = 0;
        chk("R10 irq raised", {eop_pulse, term_irq}, 2'b01);
        repeat (5) step();
        chk("R11 irq held", term_irq, 1);
        wr(8'h03);
        chk("R4 reserved code keeps irq", {term_irq, sg_status}, {1'b1, st(0, 1, 1, 1, 1, 0)});
        wr(8'h01);
        chk("R11 start clears irq", term_irq, 0);

        // R3 stop in mid-list
        fetch_ack = 1; step(); fetch_ack = 0;
        wr(8'h02);
        chk("R3 stop mid list", {chan_mask, chan_req, sg_status}, {2'b10, st(0, 0, 1, 1, 0, 0)});

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule